// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Access Sequencer

This block drives a single DRAM bank whose sense amplifiers keep one row open as a row buffer. A requester presents one read at a time on a valid/ready handshake, giving a 12-bit row and a 12-bit column. The block remembers which row, if any, sits in the buffer. It classes the request as a hit, an access to an empty buffer or a conflict with a different open row.

The block then issues the command sequence that the class needs on a shared command address bus. A conflict first writes the open row back. An empty buffer or a conflict then activates the new row with a row strobe. Every class finishes with a column strobe. The byte that the array returns at the column strobe is shifted out one bit per cycle. The access class and a running latency count are reported with the data. After an access the row stays open, so that later requests to it are served as hits.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, req_ready is 1, rd_valid, rd_done, rd_bit and all three command strobes are 0, acc_class is 2'b00 and acc_latency is 0. The row buffer holds no row, so the first accepted request is classed as empty.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 up to and including the rd_done cycle, and it returns to 1 in the cycle after rd_done.
- R3: From the cycle after acceptance, acc_class holds the class of the accepted request until the next acceptance. The codes are 2'b00 for a hit (open row equals the requested row), 2'b01 for empty (no open row) and 2'b10 for a conflict (a different row is open).
- R4: A hit issues only cmd_cas, in the first cycle after acceptance. rd_done falls T_CAS+BITS cycles after the accepting edge (12 with the defaults).
- R5: An empty access issues cmd_ras in the first cycle, then cmd_cas T_ACT cycles later. rd_done falls T_ACT+T_CAS+BITS cycles after acceptance (24 with the defaults).
- R6: A conflict issues cmd_wb in the first cycle, cmd_ras T_WB cycles later and cmd_cas T_ACT cycles after that. rd_done falls T_WB+T_ACT+T_CAS+BITS cycles after acceptance (36 with the defaults). This keeps the ratio 1:2:3 to the hit path.
- R7: cmd_addr carries the old open row for the whole write-back phase, the requested row for the whole activate phase and the column for the whole column phase. It is 0 otherwise, and at most one strobe is high in any cycle.
- R8: The byte on col_data in the cmd_cas cycle is returned on rd_bit most significant bit first. It takes BITS consecutive cycles, starting right after the column phase, with rd_valid high for exactly those cycles and rd_bit 0 whenever rd_valid is 0.
- R9: rd_done is a one-cycle pulse in the cycle of the last data bit. acc_latency counts the cycles since the accepting edge, equals the class latency in the rd_done cycle, and is 0 while idle.
- R10: A row that has been activated stays open after the access, so that a later request to that row is a hit.
- R11: req_valid while req_ready is 0 has no effect: no command, class or data changes for it until it is accepted after rd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_row | input | 12 | Requested row |
| req_col | input | 12 | Requested column |
| cmd_wb | output | 1 | Write-back strobe for the open row |
| cmd_ras | output | 1 | Row activate strobe |
| cmd_cas | output | 1 | Column strobe |
| cmd_addr | output | 12 | Shared row/column command address |
| col_data | input | 8 | Byte returned by the array in the column strobe cycle |
| rd_bit | output | 1 | Serial read data |
| rd_valid | output | 1 | rd_bit carries data |
| rd_done | output | 1 | Last data bit of the access |
| acc_class | output | 2 | Class of the current or last access |
| acc_latency | output | 6 | Cycles since acceptance |

## Verification
The end of one access and the arrival of the next can fall together. The last data bit and rd_done come in the same cycle in which a new request is already waiting on req_valid. The bench provokes this by keeping req_valid high straight after each acceptance with the next request, so every following request stands during the whole busy period. A behavioural model is compared each cycle and judges that the waiting request causes no command and is accepted only in the cycle after rd_done. Its class must reflect the row that the finishing access left open.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'b00,
    CLS_EMPTY    = 2'b01,
    CLS_CONFLICT = 2'b10
  } acc_cls_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WB,
    PH_ACT,
    PH_CAS,
    PH_DATA
  } phase_e;

endpackage

// File: rtl/row_tracker.sv
module row_tracker
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] probe_row,
  input  logic             load_en,
  input  logic [ROW_W-1:0] load_row,
  output acc_cls_e         cls,
  output logic [ROW_W-1:0] open_row
);

  logic             vld_q, vld_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    vld_d = vld_q;
    row_d = row_q;
    if (load_en) begin
      vld_d = 1'b1;
      row_d = load_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else begin
      vld_q <= vld_d;
      row_q <= row_d;
    end
  end

  always_comb begin
    if (!vld_q)                 cls = CLS_EMPTY;
    else if (probe_row == row_q) cls = CLS_HIT;
    else                        cls = CLS_CONFLICT;
  end

  assign open_row = row_q;

  AST_OPEN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cls != CLS_EMPTY)); // R10

endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import dram_seq_pkg::*;
#(
  parameter int T_WB  = 12,
  parameter int T_ACT = 12,
  parameter int T_CAS = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  acc_cls_e start_cls,
  input  logic     ser_last,
  output phase_e   phase,
  output logic     wb_stb,
  output logic     act_stb,
  output logic     cas_stb
);

  localparam int TMAX = (T_WB > T_ACT) ? ((T_WB > T_CAS) ? T_WB : T_CAS)
                                       : ((T_ACT > T_CAS) ? T_ACT : T_CAS);
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] WB_LD  = CW'(T_WB - 1);
  localparam logic [CW-1:0] ACT_LD = CW'(T_ACT - 1);
  localparam logic [CW-1:0] CAS_LD = CW'(T_CAS - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    en    = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          en = 1'b1;
          case (start_cls)
            CLS_CONFLICT: begin ph_d = PH_WB;  cnt_d = WB_LD;  end
            CLS_EMPTY:    begin ph_d = PH_ACT; cnt_d = ACT_LD; end
            default:      begin ph_d = PH_CAS; cnt_d = CAS_LD; end
          endcase
        end
      end
      PH_WB, PH_ACT, PH_CAS: begin
        en = 1'b1;
        if (cnt_q == '0) begin
          case (ph_q)
            PH_WB:   begin ph_d = PH_ACT; cnt_d = ACT_LD; end
            PH_ACT:  begin ph_d = PH_CAS; cnt_d = CAS_LD; end
            default: begin ph_d = PH_DATA; cnt_d = '0;    end
          endcase
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_DATA: begin
        if (ser_last) begin
          en   = 1'b1;
          ph_d = PH_IDLE;
        end
      end
      default: begin
        en   = 1'b1;
        ph_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase   = ph_q;
  assign wb_stb  = (ph_q == PH_WB)  && (cnt_q == WB_LD);
  assign act_stb = (ph_q == PH_ACT) && (cnt_q == ACT_LD);
  assign cas_stb = (ph_q == PH_CAS) && (cnt_q == CAS_LD);

  AST_WB_THEN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WB && cnt_q == '0) |=> act_stb); // R6
  AST_ACT_THEN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACT && cnt_q == '0) |=> cas_stb); // R5

endmodule

// File: rtl/bit_serializer.sv
module bit_serializer #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] din,
  input  logic            shift,
  output logic            bit_o,
  output logic            last
);

  localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BITS - 1);

  logic [BITS-1:0] sh_q, sh_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic            en;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    en    = load | shift;
    if (load) begin
      sh_d  = din;
      idx_d = '0;
    end else if (shift) begin
      sh_d  = sh_q << 1;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign bit_o = shift & sh_q[BITS-1];
  assign last  = shift && (idx_q == LAST_IDX);

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int BITS  = 8,
  parameter int T_WB  = 12,
  parameter int T_ACT = 12,
  parameter int T_CAS = 4,
  localparam int AW          = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int HIT_TOTAL   = T_CAS + BITS,
  localparam int EMPTY_TOTAL = T_ACT + HIT_TOTAL,
  localparam int CONF_TOTAL  = T_WB + EMPTY_TOTAL,
  localparam int LAT_W       = $clog2(CONF_TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             cmd_wb,
  output logic             cmd_ras,
  output logic             cmd_cas,
  output logic [AW-1:0]    cmd_addr,
  input  logic [BITS-1:0]  col_data,
  output logic             rd_bit,
  output logic             rd_valid,
  output logic             rd_done,
  output logic [1:0]       acc_class,
  output logic [LAT_W-1:0] acc_latency
);

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  phase_e           phase;
  acc_cls_e         cls_now, cls_q, cls_d;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             accept, ser_last, shift;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid & req_ready;
  assign shift     = (phase == PH_DATA);

  row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .probe_row (req_row),
    .load_en   (cmd_ras),
    .load_row  (row_q),
    .cls       (cls_now),
    .open_row  (open_row)
  );

  phase_seq #(.T_WB(T_WB), .T_ACT(T_ACT), .T_CAS(T_CAS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (accept),
    .start_cls (cls_now),
    .ser_last  (ser_last),
    .phase     (phase),
    .wb_stb    (cmd_wb),
    .act_stb   (cmd_ras),
    .cas_stb   (cmd_cas)
  );

  bit_serializer #(.BITS(BITS)) u_ser (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (cmd_cas),
    .din   (col_data),
    .shift (shift),
    .bit_o (rd_bit),
    .last  (ser_last)
  );

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    cls_d = cls_q;
    if (accept) begin
      row_d = req_row;
      col_d = req_col;
      cls_d = cls_now;
    end
  end

  always_comb begin
    lat_d = lat_q;
    if (accept)             lat_d = LAT_W'(1);
    else if (ser_last)      lat_d = '0;
    else if (lat_q != '0)   lat_d = lat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      row_q <= '0;
      col_q <= '0;
      cls_q <= CLS_HIT;
      lat_q <= '0;
    end else begin
      if (accept) begin
        row_q <= row_d;
        col_q <= col_d;
        cls_q <= cls_d;
      end
      lat_q <= lat_d;
    end
  end

  always_comb begin
    case (phase)
      PH_WB:   cmd_addr = AW'(open_row);
      PH_ACT:  cmd_addr = AW'(row_q);
      PH_CAS:  cmd_addr = AW'(col_q);
      default: cmd_addr = '0;
    endcase
  end

  assign rd_valid    = shift;
  assign rd_done     = ser_last;
  assign acc_class   = cls_q;
  assign acc_latency = lat_q;

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_done && cls_q == CLS_HIT) |-> (acc_latency == LAT_W'(HIT_TOTAL))); // R4
  AST_EMPTY_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_done && cls_q == CLS_EMPTY) |-> (acc_latency == LAT_W'(EMPTY_TOTAL))); // R5
  AST_CONF_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_done && cls_q == CLS_CONFLICT) |-> (acc_latency == LAT_W'(CONF_TOTAL))); // R6
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_done |=> req_ready); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({cmd_wb, cmd_ras, cmd_cas})); // R7
  AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_done |-> rd_valid); // R9
  AST_BUSY_NO_CLASS_CHANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!req_ready && !$past(accept)) |-> $stable(acc_class)); // R11

endmodule

// File: tb/dram_bank_seq_tb.sv
module dram_bank_seq_tb_top;

  localparam int T_WB  = 12;
  localparam int T_ACT = 12;
  localparam int T_CAS = 4;
  localparam int BITS  = 8;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [11:0] req_row;
  logic [11:0] req_col;
  logic        cmd_wb, cmd_ras, cmd_cas;
  logic [11:0] cmd_addr;
  logic [7:0]  col_data;
  logic        rd_bit, rd_valid, rd_done;
  logic [1:0]  acc_class;
  logic [5:0]  acc_latency;

  int total_checks = 0;
  int bad_checks   = 0;
  bit model_on     = 0;
  int cyc          = 0;

  dram_bank_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col),
    .cmd_wb(cmd_wb), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_addr(cmd_addr),
    .col_data(col_data),
    .rd_bit(rd_bit), .rd_valid(rd_valid), .rd_done(rd_done),
    .acc_class(acc_class), .acc_latency(acc_latency)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [11:0] r, input logic [11:0] c);
    pat = r[7:0] ^ {c[3:0], c[11:8]} ^ {r[11:8], c[7:4]} ^ 8'h5A;
  endfunction

  // array model: remembers the activated row, answers the column strobe
  logic [11:0] arr_row = '0;
  always @(posedge clk) if (cmd_ras) arr_row <= cmd_addr;
  always_comb col_data = pat(arr_row, cmd_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy = 0;
  int          m_t = 0, m_cls = 0, m_total = 0, m_pre = 0, m_act0 = 0;
  logic [11:0] m_old = '0, m_row = '0, m_col = '0, m_open = '0;
  bit          m_vld = 0;
  logic [7:0]  m_byte = '0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
    if (model_on) begin
      int e_addr, e_bit, di;
      bit e_wb, e_ras, e_cas, e_val, e_done;
      e_addr = 0; e_bit = 0; e_wb = 0; e_ras = 0; e_cas = 0; e_val = 0; e_done = 0;
      if (m_busy) begin
        if (m_cls == 2 && m_t <= T_WB) e_addr = m_old;
        else if (m_cls != 0 && m_t <= m_pre) e_addr = m_row;
        else if (m_t <= m_pre + T_CAS) e_addr = m_col;
        e_wb  = (m_cls == 2) && (m_t == 1);
        e_ras = (m_cls != 0) && (m_t == m_act0);
        e_cas = (m_t == m_pre + 1);
        if (m_t > m_pre + T_CAS) begin
          di    = m_t - m_pre - T_CAS - 1;
          e_val = 1;
          e_bit = m_byte[7 - di];
        end
        e_done = (m_t == m_total);
      end
      chk(req_ready == !m_busy, "R2/R11 req_ready", req_ready, !m_busy);
      chk(acc_class == m_cls[1:0], "R3/R10 acc_class", acc_class, m_cls);
      chk(cmd_wb == e_wb, "R6 cmd_wb", cmd_wb, e_wb);
      chk(cmd_ras == e_ras, "R5/R6 cmd_ras", cmd_ras, e_ras);
      chk(cmd_cas == e_cas, "R4 cmd_cas", cmd_cas, e_cas);
      chk(cmd_addr == e_addr[11:0], "R7 cmd_addr", cmd_addr, e_addr);
      chk(rd_valid == e_val, "R8 rd_valid", rd_valid, e_val);
      chk(rd_bit == e_bit[0], "R8 rd_bit", rd_bit, e_bit);
      chk(rd_done == e_done, "R9 rd_done", rd_done, e_done);
      chk(acc_latency == (m_busy ? m_t : 0), "R9 acc_latency", acc_latency, m_busy ? m_t : 0);
      // advance to the next cycle
      if (m_busy) begin
        if (m_t == m_total) m_busy = 0;
        else m_t++;
      end else if (req_valid) begin
        m_row = req_row; m_col = req_col; m_old = m_open;
        if (!m_vld) m_cls = 1;
        else if (m_open == req_row) m_cls = 0;
        else m_cls = 2;
        m_pre   = (m_cls == 2) ? T_WB + T_ACT : (m_cls == 1) ? T_ACT : 0;
        m_act0  = (m_cls == 2) ? T_WB + 1 : 1;
        m_total = m_pre + T_CAS + BITS;
        m_byte  = pat(req_row, req_col);
        m_open  = req_row; m_vld = 1;
        m_t = 1; m_busy = 1;
      end
    end
  end

  task automatic send(input logic [11:0] r, input logic [11:0] c);
    @(posedge clk); #1;
    req_valid = 1'b1; req_row = r; req_col = c;
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_row = '0; req_col = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rd_valid == 1'b0 && rd_done == 1'b0 && rd_bit == 1'b0, "R1 data idle", rd_valid, 0);
    chk({cmd_wb, cmd_ras, cmd_cas} == 3'b000, "R1 strobes", {cmd_wb, cmd_ras, cmd_cas}, 0);
    chk(acc_class == 2'b00 && acc_latency == 0, "R1 class/latency", acc_class, 0);
    model_on = 1;
    send(12'd5, 12'd3);       // R1/R5: first access empty
    send(12'd5, 12'd9);       // R4/R10: hit, back-to-back (R11)
    idle(6);
    send(12'd7, 12'd1);       // R6: conflict
    send(12'd7, 12'd2);       // R4 hit
    send(12'd9, 12'd0);       // R6 conflict, waits while busy (R11)
    send(12'd9, 12'd4095);    // R4 hit, column boundary
    send(12'd4095, 12'd4095); // R6 conflict, row boundary
    idle(3);
    send(12'd0, 12'd0);       // R6 conflict to row 0
    send(12'd0, 12'hA5C);     // R4 hit
    idle(60);
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule